// File: doc/BRIEF.md
# Serial Receive Engine with Character Compare and Idle Time-out

This block turns an asynchronous serial line into 8-bit characters. A baud divider outside the block supplies a single-cycle enable sixteen times per bit period. The block hunts for a falling edge, confirms the start bit half a bit later and samples each data bit at its centre, least significant bit first. It then checks an optional parity bit and the stop bit, and places the result in a holding register with a ready flag. An optional 2-of-3 majority filter cleans the line before any of this happens.

Each completed character is compared against a window set by two 8-bit bounds. In the flag-only setting every character is delivered and the compare only raises a match flag. In the gated setting characters are thrown away until one of them matches. An idle counter, programmed in bit periods, flags a quiet line. It can be armed at once, or told to wait for the next character before it starts counting. Single-cycle command strobes enable, disable or reset the receiver and clear the sticky status.

Top module: `serial_rx_matcher`

## Requirements
- R1: The line idles high. A low level seen on a tick starts a candidate start bit. If the line is high again when that start bit is rechecked half a bit (8 ticks) later, the candidate is dropped and nothing is delivered. Otherwise 8 data bits, LSB first, are sampled one bit period (16 ticks) apart at their centres.
- R2: With `filt_en` high, the receiver sees the 2-of-3 majority of the last three tick samples of the line. A one-tick pulse of the opposite level at the centre of any bit then leaves the received character unchanged.
- R3: `par_mode` selects the parity handling after the data bits: 0 even, 1 odd, 2 bit must be 0, 3 bit must be 1, 4 (and above) no parity bit in the frame. A parity bit that differs from the expected value sets `par_err`.
- R4: A stop bit sampled low sets `frm_err`. The character is still delivered.
- R5: A delivered character appears on `hold_data` and sets `rdy`. A `hold_rd` pulse clears `rdy`.
- R6: If a character is delivered while `rdy` is still set and no read happens in the same cycle, `ovr` is set and the new character replaces the old one.
- R7: A character matches when `cmp_lo <= c <= cmp_hi`. If `cmp_lo > cmp_hi`, only `c == cmp_lo` matches. With `cmp_gate` low, every character is delivered and a delivered match sets `cmp_hit`.
- R8: With `cmp_gate` high, non-matching characters are discarded and leave `rdy`, `hold_data` and the flags untouched, until a match arrives. The matching character and all later ones are delivered. The receiver stays armed until a status clear or a receiver reset.
- R9: With `cmp_use_par` high, a character with a parity error never counts as a match. With it low, parity has no effect on the compare.
- R10: `cmd_clr_stat` clears `ovr`, `frm_err`, `par_err` and `cmp_hit`, and disarms the gate. It leaves `rdy` unchanged.
- R11: `cmd_to_rearm` clears `idle_to` and starts counting idle time at once. `cmd_to_start` clears it and waits for the next completed character before counting. `idle_to` sets after `idle_limit` bit periods with no frame in progress. A limit of 0 never sets it.
- R12: After reset the receiver is disabled and all outputs are 0. When `cmd_rx_on` and `cmd_rx_off` come in the same cycle, the receiver ends up disabled. `cmd_rx_rst` clears `rdy` and aborts any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial receive line |
| filt_en | input | 1 | Enable 2-of-3 majority line filter |
| par_mode | input | 3 | Parity selection (R3 encoding) |
| cmp_lo | input | 8 | Lower compare bound |
| cmp_hi | input | 8 | Upper compare bound |
| cmp_gate | input | 1 | Discard characters until a compare match |
| cmp_use_par | input | 1 | Parity error vetoes a compare match |
| idle_limit | input | 8 | Idle time-out in bit periods, 0 disables |
| cmd_rx_on | input | 1 | Enable receiver strobe |
| cmd_rx_off | input | 1 | Disable receiver strobe |
| cmd_rx_rst | input | 1 | Receiver reset strobe |
| cmd_clr_stat | input | 1 | Clear sticky status strobe |
| cmd_to_start | input | 1 | Arm time-out after next character |
| cmd_to_rearm | input | 1 | Restart time-out immediately |
| hold_rd | input | 1 | Holding register read strobe |
| hold_data | output | 8 | Received character |
| rdy | output | 1 | Character waiting |
| ovr | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| idle_to | output | 1 | Idle time-out flag |
| cmp_hit | output | 1 | Compare match flag |

## Verification
The bench sends a one-tick low pulse on an idle line. A receiver that skipped the mid-bit recheck would lock onto it and lose alignment with the next real frame. It puts one-tick pulses at bit centres with the filter on, which a missing or mis-voted filter would turn into flipped bits. It sets the bounds in inverted order and expects only an exact match, so a design that simply compared against both bounds would miss or over-match. It sends non-matching characters in gated mode, where a leaky gate would raise `rdy`. It starts the idle counter in its wait-for-character setting, where a counter that began at once would fire early, and uses a zero limit that must never fire.

// File: rtl/serial_rx_matcher.sv
module serial_rx_matcher #(
  parameter int DW  = 8,
  parameter int OSR = 16,
  parameter int TOW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rxd,
  input  logic          filt_en,
  input  logic [2:0]    par_mode,
  input  logic [DW-1:0] cmp_lo,
  input  logic [DW-1:0] cmp_hi,
  input  logic          cmp_gate,
  input  logic          cmp_use_par,
  input  logic [TOW-1:0] idle_limit,
  input  logic          cmd_rx_on,
  input  logic          cmd_rx_off,
  input  logic          cmd_rx_rst,
  input  logic          cmd_clr_stat,
  input  logic          cmd_to_start,
  input  logic          cmd_to_rearm,
  input  logic          hold_rd,
  output logic [DW-1:0] hold_data,
  output logic          rdy,
  output logic          ovr,
  output logic          frm_err,
  output logic          par_err,
  output logic          idle_to,
  output logic          cmp_hit
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] BLAST = BW'(DW - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t            st;
  logic [2:0]     smp;
  logic           rx_en, armed, par_bit, to_wait, to_run, exp_par;
  logic [CW-1:0]  tcnt, to_sub;
  logic [BW-1:0]  bcnt;
  logic [DW-1:0]  shf;
  logic [TOW-1:0] to_per;

  wire maj     = (smp[0] & smp[1]) | (smp[1] & smp[2]) | (smp[0] & smp[2]);
  wire line    = filt_en ? maj : smp[0];
  wire has_par = par_mode < 3'd4;
  wire abort   = cmd_rx_rst || cmd_rx_off || !rx_en;
  wire at_last = tcnt == LAST;
  wire [CW-1:0] tnext = at_last ? '0 : tcnt + 1'b1;
  wire done    = !abort && tick16 && at_last && (st == S_STOP);

  always_comb begin
    case (par_mode)
      3'd0:    exp_par = ^shf;
      3'd1:    exp_par = ~^shf;
      3'd2:    exp_par = 1'b0;
      default: exp_par = 1'b1;
    endcase
  end

  wire bad_par = has_par && (par_bit != exp_par);
  wire in_rng  = (cmp_lo <= cmp_hi) ? (shf >= cmp_lo && shf <= cmp_hi) : (shf == cmp_lo);
  wire cmp_ok  = in_rng && !(cmp_use_par && bad_par);
  wire accept  = done && (!cmp_gate || armed || cmp_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp <= 3'b111;
    else if (tick16) smp <= {smp[1:0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_en <= 1'b0;
    else if (cmd_rx_off) rx_en <= 1'b0;
    else if (cmd_rx_on) rx_en <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tcnt    <= '0;
      bcnt    <= '0;
      shf     <= '0;
      par_bit <= 1'b0;
    end else if (abort) begin
      st <= S_IDLE;
    end else if (tick16) begin
      case (st)
        S_IDLE:
          if (!line) begin
            st   <= S_START;
            tcnt <= CW'(1);
          end
        S_START:
          if (tcnt == MID) begin
            st   <= line ? S_IDLE : S_DATA;
            tcnt <= '0;
            bcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        S_DATA: begin
          tcnt <= tnext;
          if (at_last) begin
            shf  <= {line, shf[DW-1:1]};
            bcnt <= bcnt + 1'b1;
            if (bcnt == BLAST) st <= has_par ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          tcnt <= tnext;
          if (at_last) begin
            par_bit <= line;
            st      <= S_STOP;
          end
        end
        default: begin
          tcnt <= tnext;
          if (at_last) st <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      rdy       <= 1'b0;
      ovr       <= 1'b0;
      frm_err   <= 1'b0;
      par_err   <= 1'b0;
      cmp_hit   <= 1'b0;
      armed     <= 1'b0;
    end else begin
      if (accept) hold_data <= shf;
      if (cmd_rx_rst) rdy <= 1'b0;
      else if (accept) rdy <= 1'b1;
      else if (hold_rd) rdy <= 1'b0;
      ovr     <= (ovr && !cmd_clr_stat) || (accept && rdy && !hold_rd);
      frm_err <= (frm_err && !cmd_clr_stat) || (accept && !line);
      par_err <= (par_err && !cmd_clr_stat) || (accept && bad_par);
      cmp_hit <= (cmp_hit && !cmd_clr_stat) || (accept && cmp_ok);
      if (cmd_rx_rst || cmd_clr_stat) armed <= 1'b0;
      else if (done && cmp_ok) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_wait <= 1'b0;
      to_run  <= 1'b0;
      idle_to <= 1'b0;
      to_sub  <= '0;
      to_per  <= '0;
    end else if (cmd_to_rearm) begin
      to_run  <= 1'b1;
      to_wait <= 1'b0;
      idle_to <= 1'b0;
      to_sub  <= '0;
      to_per  <= '0;
    end else if (cmd_to_start) begin
      to_wait <= 1'b1;
      to_run  <= 1'b0;
      idle_to <= 1'b0;
      to_sub  <= '0;
      to_per  <= '0;
    end else if (done) begin
      to_sub <= '0;
      to_per <= '0;
      if (to_wait) begin
        to_wait <= 1'b0;
        to_run  <= 1'b1;
      end
    end else if (st != S_IDLE) begin
      to_sub <= '0;
      to_per <= '0;
    end else if (to_run && tick16 && idle_limit != '0) begin
      if (to_sub == LAST) begin
        to_sub <= '0;
        to_per <= to_per + 1'b1;
        if (to_per == idle_limit - 1'b1) begin
          idle_to <= 1'b1;
          to_run  <= 1'b0;
        end
      end else begin
        to_sub <= to_sub + 1'b1;
      end
    end
  end

  AST_RDY_DROP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rd && !accept |=> !rdy); // R5
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rdy)); // R6
  AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rx_on && cmd_rx_off |=> (st == S_IDLE) && !rx_en); // R12
  AST_NO_TO_WHEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_to) |-> $past(idle_limit) != '0); // R11
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr_stat && !accept |=> !ovr && !frm_err && !par_err && !cmp_hit); // R10
  AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_gate && !armed && done && !cmp_ok |=> $stable(hold_data) && !$rose(rdy)); // R8
endmodule

// File: tb/serial_rx_matcher_bench.sv
module serial_rx_matcher_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic filt_en = 1'b0, cmp_gate = 1'b0, cmp_use_par = 1'b0;
  logic [2:0] par_mode = 3'd4;
  logic [7:0] cmp_lo = 8'h00, cmp_hi = 8'h00, idle_limit = 8'h00;
  logic cmd_rx_on = 0, cmd_rx_off = 0, cmd_rx_rst = 0, cmd_clr_stat = 0;
  logic cmd_to_start = 0, cmd_to_rearm = 0, hold_rd = 0;
  logic [7:0] hold_data;
  logic rdy, ovr, frm_err, par_err, idle_to, cmp_hit;
  int n_chk = 0, n_fail = 0;

  serial_rx_matcher u_serial_rx_matcher (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .filt_en(filt_en),
    .par_mode(par_mode), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .cmp_gate(cmp_gate),
    .cmp_use_par(cmp_use_par), .idle_limit(idle_limit), .cmd_rx_on(cmd_rx_on),
    .cmd_rx_off(cmd_rx_off), .cmd_rx_rst(cmd_rx_rst), .cmd_clr_stat(cmd_clr_stat),
    .cmd_to_start(cmd_to_start), .cmd_to_rearm(cmd_to_rearm), .hold_rd(hold_rd),
    .hold_data(hold_data), .rdy(rdy), .ovr(ovr), .frm_err(frm_err),
    .par_err(par_err), .idle_to(idle_to), .cmp_hit(cmp_hit));

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    forever begin
      repeat (TDIV - 1) begin @(negedge clk); tick16 = 1'b0; end
      @(negedge clk); tick16 = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tk();
    do @(posedge clk); while (!tick16);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) tk();
  endtask

  task automatic cmd(input int which);
    @(negedge clk);
    case (which)
      0: cmd_rx_on = 1; 1: cmd_rx_off = 1; 2: cmd_rx_rst = 1;
      3: cmd_clr_stat = 1; 4: cmd_to_start = 1; 5: cmd_to_rearm = 1;
      6: hold_rd = 1;
      default: begin cmd_rx_on = 1; cmd_rx_off = 1; end
    endcase
    @(negedge clk);
    {cmd_rx_on, cmd_rx_off, cmd_rx_rst, cmd_clr_stat, cmd_to_start, cmd_to_rearm, hold_rd} = '0;
  endtask

  function automatic logic good_par(input logic [7:0] d);
    case (par_mode)
      3'd0: return ^d;
      3'd1: return ~^d;
      3'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic frame(input logic [7:0] d, input logic pb, input logic stopb, input logic [10:0] gmask);
    logic [10:0] fr;
    int n;
    fr = '1;
    fr[0] = 1'b0;
    fr[8:1] = d;
    if (par_mode < 3'd4) begin fr[9] = pb; fr[10] = stopb; n = 11; end
    else begin fr[9] = stopb; n = 10; end
    for (int i = 0; i < n; i++)
      for (int t = 0; t < 16; t++) begin
        rxd = (gmask[i] && t == 8) ? ~fr[i] : fr[i];
        tk();
      end
    rxd = 1'b1;
    ticks(16);
  endtask

  task automatic send(input logic [7:0] d);
    frame(d, good_par(d), 1'b1, '0);
  endtask

  task automatic t_reset();
    chk("R12 reset flags", {rdy, ovr, frm_err, par_err, idle_to, cmp_hit}, 0);
    chk("R12 reset data", hold_data, 0);
    send(8'h33);
    chk("R12 disabled ignores line", rdy, 0);
    cmd(0);
  endtask

  task automatic t_basic();
    send(8'h5A);
    chk("R1 data 5A", hold_data, 8'h5A);
    chk("R5 rdy set", rdy, 1);
    cmd(6);
    chk("R5 read clears rdy", rdy, 0);
    send(8'h81);
    chk("R1 data 81", hold_data, 8'h81);
    cmd(6);
  endtask

  task automatic t_glitch();
    rxd = 1'b0; tk(); rxd = 1'b1; ticks(32);
    chk("R1 short low rejected", rdy, 0);
    send(8'h3C);
    chk("R1 aligned after glitch", hold_data, 8'h3C);
    cmd(6);
  endtask

  task automatic t_filter();
    filt_en = 1'b1;
    frame(8'hA5, 1'b0, 1'b1, 11'b000_0000_0111);
    chk("R2 filtered char", hold_data, 8'hA5);
    chk("R2 filtered rdy", rdy, 1);
    cmd(6);
    filt_en = 1'b0;
  endtask

  task automatic t_parity();
    for (int m = 0; m < 4; m++) begin
      par_mode = 3'(m);
      send(8'h96 ^ 8'(m));
      chk("R3 correct parity", par_err, 0);
      chk("R3 parity data", hold_data, 8'h96 ^ 8'(m));
      cmd(6);
    end
    par_mode = 3'd0;
    frame(8'h07, ~good_par(8'h07), 1'b1, '0);
    chk("R3 even wrong", par_err, 1);
    cmd(3); cmd(6);
    par_mode = 3'd3;
    frame(8'h07, 1'b0, 1'b1, '0);
    chk("R3 mark got 0", par_err, 1);
    cmd(3); cmd(6);
    par_mode = 3'd4;
    send(8'hE1);
    chk("R3 no parity frame", hold_data, 8'hE1);
    chk("R3 no parity flag", par_err, 0);
    cmd(6);
  endtask

  task automatic t_frame();
    frame(8'h44, 1'b0, 1'b0, '0);
    chk("R4 frm_err set", frm_err, 1);
    chk("R4 char delivered", hold_data, 8'h44);
    cmd(3);
    chk("R10 clear frm_err", frm_err, 0);
    chk("R10 clear keeps rdy", rdy, 1);
    cmd(6);
  endtask

  task automatic t_overrun();
    send(8'h11);
    send(8'h22);
    chk("R6 ovr set", ovr, 1);
    chk("R6 newest kept", hold_data, 8'h22);
    cmd(6); cmd(3);
    chk("R10 clear ovr", ovr, 0);
  endtask

  task automatic t_cmp();
    cmp_lo = 8'h30; cmp_hi = 8'h39;
    send(8'h35);
    chk("R7 in range", cmp_hit, 1);
    cmd(3); cmd(6);
    send(8'h41);
    chk("R7 out of range", cmp_hit, 0);
    chk("R7 flag-only delivers", rdy, 1);
    cmd(6);
    cmp_lo = 8'h50; cmp_hi = 8'h10;
    send(8'h20);
    chk("R7 inverted no range", cmp_hit, 0);
    cmd(6);
    send(8'h50);
    chk("R7 inverted exact", cmp_hit, 1);
    cmd(6); cmd(3);
  endtask

  task automatic t_gate();
    cmp_gate = 1'b1; cmp_lo = 8'h7E; cmp_hi = 8'h7E;
    cmd(3);
    send(8'h11);
    chk("R8 discarded rdy", rdy, 0);
    chk("R8 discarded data", hold_data, 8'h50);
    send(8'h7E);
    chk("R8 match delivered", hold_data, 8'h7E);
    cmd(6);
    send(8'h22);
    chk("R8 armed delivers", hold_data, 8'h22);
    chk("R8 armed rdy", rdy, 1);
    cmd(6);
    cmp_gate = 1'b0; cmd(3);
  endtask

  task automatic t_cmppar();
    par_mode = 3'd0; cmp_lo = 8'h40; cmp_hi = 8'h40; cmp_use_par = 1'b1;
    frame(8'h40, 1'b0, 1'b1, '0);
    chk("R9 parity veto", cmp_hit, 0);
    chk("R9 parity err", par_err, 1);
    cmd(3); cmd(6);
    cmp_use_par = 1'b0;
    frame(8'h40, 1'b0, 1'b1, '0);
    chk("R9 parity ignored", cmp_hit, 1);
    cmd(3);
    chk("R10 clear all", {ovr, frm_err, par_err, cmp_hit}, 0);
    cmd(6);
    par_mode = 3'd4;
  endtask

  task automatic t_timeout();
    idle_limit = 8'd3;
    cmd(5);
    ticks(40);
    chk("R11 not yet", idle_to, 0);
    ticks(16);
    chk("R11 fired", idle_to, 1);
    cmd(5);
    chk("R11 rearm clears", idle_to, 0);
    idle_limit = 8'd0;
    cmd(5);
    ticks(100);
    chk("R11 zero disables", idle_to, 0);
    idle_limit = 8'd3;
    cmd(4);
    ticks(100);
    chk("R11 waits for char", idle_to, 0);
    send(8'h6B);
    ticks(10);
    chk("R11 after char early", idle_to, 0);
    ticks(24);
    chk("R11 after char fired", idle_to, 1);
    cmd(6);
    idle_limit = 8'd0;
  endtask

  task automatic t_rxctl();
    send(8'h5F);
    cmd(2);
    chk("R12 rx reset clears rdy", rdy, 0);
    cmd(7);
    send(8'h60);
    chk("R12 off wins", rdy, 0);
    cmd(0);
    send(8'h61);
    chk("R12 re-enabled", hold_data, 8'h61);
    cmd(6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_glitch();
    t_filter();
    t_parity();
    t_frame();
    t_overrun();
    t_cmp();
    t_gate();
    t_cmppar();
    t_timeout();
    t_rxctl();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule